// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit Engine

This block is the bit layer of a slave on a single open-drain wire that a bus master controls. The wire is sampled with the system clock. The block times every low pulse the master starts and sorts each pulse into one of three kinds: a bus reset, a write slot or a read slot. After a bus reset it answers with a presence pulse. A write slot gives one received bit. In a read slot the slave stretches the low time to send a zero. A higher layer handles command decoding. That layer sees received bits as one-cycle strobes, offers transmit bits with a request and acknowledge handshake, and can ask for the faster overdrive timing.

All timing values are parameters in clock cycles, with one set for standard speed and one for overdrive. The core is one state machine with five states:
- `ST_IDLE`: the wire is high and the slave is ready for a slot.
- `ST_LOW`: the master is holding the wire low and the slot is being timed.
- `ST_PRES_WAIT`: the gap before the presence pulse.
- `ST_PRES_DRIVE`: the slave is pulling the wire low for presence.
- `ST_RECOVER`: a rest interval before the next slot.

The transitions are:
- slot start: `ST_IDLE`→`ST_LOW`, on a low wire.
- slot end: `ST_LOW`→`ST_RECOVER`, when the wire is released before the reset threshold.
- reset accept: `ST_LOW`→`ST_PRES_WAIT`, when the wire is released after the reset threshold.
- presence begin: `ST_PRES_WAIT`→`ST_PRES_DRIVE`.
- presence end: `ST_PRES_DRIVE`→`ST_RECOVER`.
- ready: `ST_RECOVER`→`ST_IDLE`.

In the requirements below, a low length L means the number of clock cycles for which `line_in` stays low. SAMPLE, RST_MIN, HOLD, PDH, PDL and REC take the values of the speed in use.

Top module: `ow_slave_link`

## Requirements
- R1: While `rst_n` is low and just after it rises, `pull_low`, `od_mode`, `rx_valid`, `tx_ack` and `bus_reset` are 0, and the slave runs at standard speed.
- R2: A write slot with low length L gives exactly one one-cycle `rx_valid` strobe. `rx_bit` is 1 when L ≤ SAMPLE and 0 when L > SAMPLE. SAMPLE is 30 cycles at standard speed and 3 cycles in overdrive. Any low longer than SAMPLE, a reset included, strobes a 0.
- R3: At standard speed, a low length of at least 480 cycles is a bus reset: `bus_reset` pulses for one cycle and the slave stays at standard speed. A shorter low gives no reset and no presence pulse.
- R4: After a bus reset, the slave waits PDH cycles (30 standard, 3 overdrive) and then pulls the wire low for exactly PDL cycles (120 standard, 12 overdrive). The timing set used is the one for the speed chosen by that reset. Three cycles of the wire-to-state latency come before the PDH gap.
- R5: In overdrive, a low length of at least 48 cycles is a bus reset. If that length is no more than 80 cycles, the slave stays in overdrive.
- R6: In overdrive, a reset with a low length above 80 cycles switches to standard speed. This covers the undefined 81 to 479 band as well as 480 and above. `od_mode` falls only in the cycle in which `bus_reset` is high.
- R7: If `tx_req` is high when a slot starts, `tx_ack` pulses for one cycle, the slot is a read slot and no `rx_valid` follows. For `tx_bit`=0 the slave pulls the wire low from slot start until its slot count reaches HOLD (30 standard, 6 overdrive). For `tx_bit`=1 it never pulls.
- R8: A one-cycle `od_req` is held as pending and takes effect at the next slot start. A request that arrives in the same cycle as the slot start also takes effect there. That slot, and the slots after it, use overdrive timing. `od_mode` rises only when a slot starts.
- R9: After a slot ends, the slave waits REC cycles (5 standard, 2 overdrive) before it can see a new slot start. A falling edge during that wait is timed from the end of the wait, so the measured low length is shorter by the cycles lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Raw wire level (unsynchronized) |
| pull_low | output | 1 | Open-drain pull-down enable for the wire |
| rx_valid | output | 1 | One-cycle strobe for a received bit |
| rx_bit | output | 1 | Value of the received bit, valid with `rx_valid` |
| tx_req | input | 1 | Higher layer offers a bit for the next slot |
| tx_bit | input | 1 | Bit to send in a read slot |
| tx_ack | output | 1 | One-cycle pulse when the offered bit is taken |
| od_req | input | 1 | One-cycle request to enter overdrive |
| od_mode | output | 1 | 1 while overdrive timing is in use |
| bus_reset | output | 1 | One-cycle pulse when a bus reset is accepted |

## Verification
Two events can land in the same clock cycle: acceptance of an overdrive request and detection of a slot start. The bench provokes this by moving a one-cycle `od_req` across cycle offsets 0 to 5 from the master's falling edge on a 10-cycle low. The received bit shows which timing set measured that slot: 0 under overdrive, 1 under standard. The result is compared with the offset at which the request reaches the state machine no later than the delayed edge. A second sweep places a new falling edge at several distances from the end of recovery and predicts the shortened low length arithmetically.

// File: rtl/ow_slave_pkg.sv
package ow_slave_pkg;

    localparam int unsigned OW_CW = 16;

    typedef logic [OW_CW-1:0] ow_cnt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_PRES_WAIT,
        ST_PRES_DRIVE,
        ST_RECOVER
    } ow_state_e;

    typedef struct packed {
        ow_cnt_t sample;
        ow_cnt_t rst_min;
        ow_cnt_t hold;
        ow_cnt_t pdh;
        ow_cnt_t pdl;
        ow_cnt_t rec;
    } ow_timing_t;

endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= RESET_VAL;
                else        chain[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= RESET_VAL;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[LAST];

endmodule

// File: rtl/ow_timing.sv
module ow_timing
    import ow_slave_pkg::*;
#(
    parameter int STD_SAMPLE  = 30,
    parameter int STD_RST_MIN = 480,
    parameter int STD_HOLD    = 30,
    parameter int STD_PDH     = 30,
    parameter int STD_PDL     = 120,
    parameter int STD_REC     = 5,
    parameter int OD_SAMPLE   = 3,
    parameter int OD_RST_MIN  = 48,
    parameter int OD_HOLD     = 6,
    parameter int OD_PDH      = 3,
    parameter int OD_PDL      = 12,
    parameter int OD_REC      = 2
) (
    input  logic       od,
    output ow_timing_t tm
);
    localparam ow_timing_t STD_SET = '{
        sample:  ow_cnt_t'(STD_SAMPLE),
        rst_min: ow_cnt_t'(STD_RST_MIN),
        hold:    ow_cnt_t'(STD_HOLD),
        pdh:     ow_cnt_t'(STD_PDH),
        pdl:     ow_cnt_t'(STD_PDL),
        rec:     ow_cnt_t'(STD_REC)
    };

    localparam ow_timing_t OD_SET = '{
        sample:  ow_cnt_t'(OD_SAMPLE),
        rst_min: ow_cnt_t'(OD_RST_MIN),
        hold:    ow_cnt_t'(OD_HOLD),
        pdh:     ow_cnt_t'(OD_PDH),
        pdl:     ow_cnt_t'(OD_PDL),
        rec:     ow_cnt_t'(OD_REC)
    };

    always_comb begin
        tm = od ? OD_SET : STD_SET;
    end

endmodule

// File: rtl/ow_slave_link.sv
module ow_slave_link
    import ow_slave_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STD_SAMPLE  = 30,
    parameter int STD_RST_MIN = 480,
    parameter int STD_HOLD    = 30,
    parameter int STD_PDH     = 30,
    parameter int STD_PDL     = 120,
    parameter int STD_REC     = 5,
    parameter int OD_SAMPLE   = 3,
    parameter int OD_RST_MIN  = 48,
    parameter int OD_KEEP_MAX = 80,
    parameter int OD_HOLD     = 6,
    parameter int OD_PDH      = 3,
    parameter int OD_PDL      = 12,
    parameter int OD_REC      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic pull_low,
    output logic rx_valid,
    output logic rx_bit,
    input  logic tx_req,
    input  logic tx_bit,
    output logic tx_ack,
    input  logic od_req,
    output logic od_mode,
    output logic bus_reset
);
    localparam ow_cnt_t KEEP_LIM = ow_cnt_t'(OD_KEEP_MAX);
    localparam ow_cnt_t ONE      = ow_cnt_t'(1);

    ow_state_e  state, state_d;
    ow_cnt_t    cnt, cnt_d, cnt_inc;
    logic       od_q, od_d;
    logic       pend_q, pend_d;
    logic       rd_q, rd_d;
    logic       rdbit_q, rdbit_d;
    logic       rx_valid_d, rx_bit_d, tx_ack_d, bus_reset_d;
    logic       line_s;
    ow_timing_t tm;

    ow_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (line_s)
    );

    ow_timing #(
        .STD_SAMPLE  (STD_SAMPLE),
        .STD_RST_MIN (STD_RST_MIN),
        .STD_HOLD    (STD_HOLD),
        .STD_PDH     (STD_PDH),
        .STD_PDL     (STD_PDL),
        .STD_REC     (STD_REC),
        .OD_SAMPLE   (OD_SAMPLE),
        .OD_RST_MIN  (OD_RST_MIN),
        .OD_HOLD     (OD_HOLD),
        .OD_PDH      (OD_PDH),
        .OD_PDL      (OD_PDL),
        .OD_REC      (OD_REC)
    ) u_timing (
        .od (od_q),
        .tm (tm)
    );

    // Next-state and next-value logic
    always_comb begin
        cnt_inc     = (&cnt) ? cnt : cnt + ONE;
        state_d     = state;
        cnt_d       = cnt;
        od_d        = od_q;
        pend_d      = pend_q | od_req;
        rd_d        = rd_q;
        rdbit_d     = rdbit_q;
        rx_valid_d  = 1'b0;
        rx_bit_d    = rx_bit;
        tx_ack_d    = 1'b0;
        bus_reset_d = 1'b0;

        unique case (state)
            ST_IDLE: begin
                if (!line_s) begin
                    // slot start
                    state_d  = ST_LOW;
                    cnt_d    = ONE;
                    rd_d     = tx_req;
                    rdbit_d  = tx_bit;
                    tx_ack_d = tx_req;
                    if (pend_q || od_req) begin
                        od_d   = 1'b1;
                        pend_d = 1'b0;
                    end
                end
            end
            ST_LOW: begin
                if (line_s) begin
                    cnt_d = ONE;
                    if (cnt >= tm.rst_min) begin
                        // reset accept; the undefined band falls back to standard
                        state_d     = ST_PRES_WAIT;
                        bus_reset_d = 1'b1;
                        od_d        = od_q && (cnt <= KEEP_LIM);
                        pend_d      = od_req;
                    end else begin
                        // slot end
                        state_d = ST_RECOVER;
                        if (!rd_q && cnt <= tm.sample) begin
                            rx_valid_d = 1'b1;
                            rx_bit_d   = 1'b1;
                        end
                    end
                end else begin
                    cnt_d = cnt_inc;
                    if (!rd_q && cnt == tm.sample) begin
                        rx_valid_d = 1'b1;
                        rx_bit_d   = 1'b0;
                    end
                end
            end
            ST_PRES_WAIT: begin
                if (cnt >= tm.pdh) begin
                    // presence begin
                    state_d = ST_PRES_DRIVE;
                    cnt_d   = ONE;
                end else begin
                    cnt_d = cnt_inc;
                end
            end
            ST_PRES_DRIVE: begin
                if (cnt >= tm.pdl) begin
                    // presence end
                    state_d = ST_RECOVER;
                    cnt_d   = ONE;
                end else begin
                    cnt_d = cnt_inc;
                end
            end
            ST_RECOVER: begin
                if (cnt >= tm.rec) begin
                    // ready
                    state_d = ST_IDLE;
                    cnt_d   = ONE;
                end else begin
                    cnt_d = cnt_inc;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = ONE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= ONE;
            od_q      <= 1'b0;
            pend_q    <= 1'b0;
            rd_q      <= 1'b0;
            rdbit_q   <= 1'b1;
            rx_valid  <= 1'b0;
            rx_bit    <= 1'b0;
            tx_ack    <= 1'b0;
            bus_reset <= 1'b0;
        end else begin
            state     <= state_d;
            cnt       <= cnt_d;
            od_q      <= od_d;
            pend_q    <= pend_d;
            rd_q      <= rd_d;
            rdbit_q   <= rdbit_d;
            rx_valid  <= rx_valid_d;
            rx_bit    <= rx_bit_d;
            tx_ack    <= tx_ack_d;
            bus_reset <= bus_reset_d;
        end
    end

    // Outputs
    always_comb begin
        pull_low = (state == ST_PRES_DRIVE) ||
                   (state == ST_LOW && rd_q && !rdbit_q && cnt < tm.hold);
        od_mode  = od_q;
    end

endmodule

// File: rtl/ow_slave_link_chk.sv
module ow_slave_link_chk
    import ow_slave_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      pull_low,
    input logic      rx_valid,
    input logic      tx_req,
    input logic      tx_ack,
    input logic      od_mode,
    input logic      bus_reset,
    input ow_state_e state
);

    // R2
    rx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R2
    rx_not_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && bus_reset));

    // R4
    pres_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !pull_low);

    // R4
    pull_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pull_low |-> (state == ST_PRES_DRIVE || state == ST_LOW));

    // R6
    od_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(od_mode) |-> bus_reset);

    // R8
    od_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(od_mode) |-> (state == ST_LOW && !bus_reset));

    // R7
    tx_ack_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ack |-> $past(tx_req));

    // R7
    tx_ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ack |=> !tx_ack);

endmodule

bind ow_slave_link ow_slave_link_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pull_low  (pull_low),
    .rx_valid  (rx_valid),
    .tx_req    (tx_req),
    .tx_ack    (tx_ack),
    .od_mode   (od_mode),
    .bus_reset (bus_reset),
    .state     (state)
);

// File: tb/ow_slave_link_tb.sv
module ow_slave_link_tb;
    localparam int CLK_PERIOD  = 10;
    localparam int STD_SAMPLE  = 30;
    localparam int STD_RST_MIN = 480;
    localparam int STD_HOLD    = 30;
    localparam int STD_PDH     = 30;
    localparam int STD_PDL     = 120;
    localparam int STD_REC     = 5;
    localparam int OD_SAMPLE   = 3;
    localparam int OD_RST_MIN  = 48;
    localparam int OD_KEEP_MAX = 80;
    localparam int OD_HOLD     = 6;
    localparam int OD_PDH      = 3;
    localparam int OD_PDL      = 12;
    localparam int OD_REC      = 2;
    localparam int WIN         = 3 + STD_PDH + STD_PDL + STD_REC + 20;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst_n, m_low, line_in, pull_low, rx_valid, rx_bit;
    logic tx_req, tx_bit, tx_ack, od_req, od_mode, bus_reset;

    assign line_in = ~(m_low | pull_low);

    ow_slave_link #(
        .SYNC_STAGES (2),
        .STD_SAMPLE  (STD_SAMPLE),  .STD_RST_MIN (STD_RST_MIN),
        .STD_HOLD    (STD_HOLD),    .STD_PDH     (STD_PDH),
        .STD_PDL     (STD_PDL),     .STD_REC     (STD_REC),
        .OD_SAMPLE   (OD_SAMPLE),   .OD_RST_MIN  (OD_RST_MIN),
        .OD_KEEP_MAX (OD_KEEP_MAX), .OD_HOLD     (OD_HOLD),
        .OD_PDH      (OD_PDH),      .OD_PDL      (OD_PDL),
        .OD_REC      (OD_REC)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .line_in (line_in), .pull_low (pull_low),
        .rx_valid (rx_valid), .rx_bit (rx_bit), .tx_req (tx_req), .tx_bit (tx_bit),
        .tx_ack (tx_ack), .od_req (od_req), .od_mode (od_mode), .bus_reset (bus_reset)
    );

    int n_chk = 0;
    int n_err = 0;
    int rx_n  = 0;
    int rs_n  = 0;
    int ack_n = 0;
    int rx_last = 0;

    always @(negedge clk) begin
        if (rx_valid)  begin rx_n++; rx_last = int'(rx_bit); end
        if (bus_reset) rs_n++;
        if (tx_ack)    ack_n++;
    end

    task automatic chk(input string req, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic master_low(input int len);
        m_low = 1'b1;
        repeat (len) @(negedge clk);
        m_low = 1'b0;
    endtask

    task automatic write_slot(input int len, input int exp_bit, input string req);
        int a;
        a = rx_n;
        master_low(len);
        idle(20);
        chk({req, " strobe count"}, rx_n - a, 1);
        chk({req, " bit value"}, rx_last, exp_bit);
    endtask

    task automatic reset_pulse(input int len, input int exp_rst, input int exp_od, input string req);
        int a, pc, first;
        a = rs_n; pc = 0; first = -1;
        master_low(len);
        for (int k = 0; k < WIN; k++) begin
            if (pull_low) begin
                pc++;
                if (first < 0) first = k;
            end
            @(negedge clk);
        end
        chk({req, " reset pulse count"}, rs_n - a, exp_rst);
        chk({"R4 presence length (", req, ")"}, pc,
            exp_rst != 0 ? (exp_od != 0 ? OD_PDL : STD_PDL) : 0);
        if (exp_rst != 0)
            chk({"R4 presence start (", req, ")"}, first,
                3 + (exp_od != 0 ? OD_PDH : STD_PDH));
        chk({req, " speed after"}, int'(od_mode), exp_od);
    endtask

    task automatic go_od();
        od_req = 1'b1;
        @(negedge clk);
        od_req = 1'b0;
        idle(3);
        write_slot(2, 1, "R8 slot after request");
        chk("R8 overdrive entered", int'(od_mode), 1);
    endtask

    task automatic read_slot(input logic b, input int od);
        int a, r;
        a = ack_n; r = rx_n;
        tx_req = 1'b1;
        tx_bit = b;
        master_low(4);
        idle(od != 0 ? 2 : 11);
        chk("R7 wire level at master sample", int'(line_in), int'(b));
        tx_req = 1'b0;
        idle(40);
        chk("R7 ack pulses", ack_n - a, 1);
        chk("R7 no receive strobe", rx_n - r, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : stim
        rst_n = 1'b0; m_low = 1'b0; od_req = 1'b0; tx_req = 1'b0; tx_bit = 1'b1;
        idle(5);
        chk("R1 pull_low in reset", int'(pull_low), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pull_low", int'(pull_low), 0);
        chk("R1 od_mode", int'(od_mode), 0);
        chk("R1 rx_valid", int'(rx_valid), 0);
        chk("R1 tx_ack", int'(tx_ack), 0);
        chk("R1 bus_reset", int'(bus_reset), 0);
        idle(5);

        // R3 standard reset threshold
        reset_pulse(STD_RST_MIN, 1, 0, "R3 std 480");
        reset_pulse(STD_RST_MIN - 1, 0, 0, "R3 std 479");
        reset_pulse(200, 0, 0, "R3 std 200");

        // R2 standard write sweep
        for (int len = 1; len <= STD_SAMPLE + 6; len++)
            write_slot(len, (len > STD_SAMPLE) ? 0 : 1, "R2 std write");

        // R8 enter overdrive, then R2 overdrive sweep
        go_od();
        for (int len = 1; len <= OD_SAMPLE + 5; len++)
            write_slot(len, (len > OD_SAMPLE) ? 0 : 1, "R2 od write");

        // R7 read slots in overdrive
        read_slot(1'b0, 1);
        read_slot(1'b1, 1);

        // R5 / R6 overdrive reset bands
        reset_pulse(OD_RST_MIN - 1, 0, 1, "R5 od 47");
        reset_pulse(OD_RST_MIN, 1, 1, "R5 od 48");
        reset_pulse(OD_KEEP_MAX, 1, 1, "R5 od 80");
        reset_pulse(OD_KEEP_MAX + 1, 1, 0, "R6 od 81");
        go_od();
        reset_pulse(200, 1, 0, "R6 od 200");
        go_od();
        reset_pulse(STD_RST_MIN, 1, 0, "R6 od 480");

        // R7 read slots at standard speed
        read_slot(1'b0, 0);
        read_slot(1'b1, 0);

        // R8 request coinciding with slot start
        for (int k = 0; k <= 5; k++) begin
            int a;
            a = rx_n;
            for (int i = 0; i < 10; i++) begin
                m_low  = 1'b1;
                od_req = (i == k);
                @(negedge clk);
            end
            m_low = 1'b0;
            od_req = 1'b0;
            idle(20);
            chk("R8 coincide strobe count", rx_n - a, 1);
            chk("R8 coincide bit (speed of slot)", rx_last, (k <= 2) ? 0 : 1);
            write_slot(10, 0, "R8 following slot in overdrive");
            chk("R8 od_mode after request", int'(od_mode), 1);
            reset_pulse(STD_RST_MIN, 1, 0, "R6 back to std");
        end

        // R9 recovery interval
        for (int g = 1; g <= 7; g++) begin
            int a, d;
            a = rx_n;
            d = (STD_REC + 1 - g > 0) ? (STD_REC + 1 - g) : 0;
            master_low(6);
            idle(g);
            master_low(STD_SAMPLE + 3);
            idle(20);
            chk("R9 strobe count", rx_n - a, 2);
            chk("R9 second bit", rx_last, (STD_SAMPLE + 3 - d > STD_SAMPLE) ? 0 : 1);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule